// File: doc/BRIEF.md
# Nine-bit UART receiver with address-mark filtering

This block is the receive side of a multidrop serial link. It recovers characters from an asynchronous line using a tick that pulses sixteen times per bit period. Each character is a low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. In nine-bit format the top bit marks the word: when it is set, the word is an address, and when it is clear, the word is a data byte.

When the address filter is on, the receiver keeps only address-marked words. Data bytes meant for other nodes never reach the four-word receive queue and never raise the interrupt. The host reads each address itself and decides whether it is the target. If it is, the host clears the filter to take in the data bytes that follow, and sets it again at the end of the packet.

The read side is a valid/ready stream. `rd_valid` is high whenever the queue holds a word, and `rd_data` then shows the oldest word. A word leaves the queue on a clock edge where both `rd_valid` and `rd_ready` are high. `rd_ready` has no effect while `rd_valid` is low. Back-pressure takes the form of queue occupancy: a word that is accepted while the queue is full is lost, and the overrun flag records the loss.

Top module: `uart9_addr_rx`

## Requirements
- R1: After reset, `rd_valid`, `irq` and `overrun` are all low.
- R2: With `fmt_sel` = 3, a frame is received as nine data bits, with the first bit after the start bit landing in `rd_data[0]` and the last in `rd_data[8]`.
- R3: With `fmt_sel` = 0, 1 or 2, a frame carries eight data bits placed in `rd_data[7:0]`, `rd_data[8]` reads 0, and the stop bit is expected after the eighth bit.
- R4: With `addr_en` high in nine-bit format, a word whose bit 8 is 0 is discarded: it is not queued and does not raise `irq`.
- R5: With `addr_en` high in nine-bit format, a word whose bit 8 is 1 is queued and raises `irq`.
- R6: With `addr_en` low, every received word is queued, whatever bit 8 holds.
- R7: The queue holds up to 4 words and returns them in arrival order, removing one per clock edge where `rd_valid` and `rd_ready` are both high.
- R8: `irq` is a level. For `irq_sel` = 0 or 1 it is high when at least 1 word is queued. For `irq_sel` = 2 it is high when at least 3 words are queued. For `irq_sel` = 3 it is high when 4 words are queued.
- R9: A word that is accepted while 4 words are queued is dropped and sets `overrun`. `overrun` stays high until a cycle with `ovr_clr` high and no new overrun.
- R10: A low pulse on `rxd` that has ended before the middle of the start bit is treated as a false start. The receiver returns to idle and no word is produced.
- R11: Each bit is decided by a majority vote of three samples taken at oversample counts 7, 8 and 9. A glitch that covers only one of those samples does not change the bit.
- R12: A frame whose stop bit is sampled low is discarded. The receiver then waits for `rxd` to return high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversample strobe, 16 pulses per bit period |
| rxd | input | 1 | Serial line, idle high |
| addr_en | input | 1 | Address filter enable |
| fmt_sel | input | 2 | Frame format: 3 = nine data bits, other values = eight |
| irq_sel | input | 2 | Interrupt level select |
| rd_data | output | 9 | Oldest queued word |
| rd_valid | output | 1 | Queue not empty |
| rd_ready | input | 1 | Host takes the word on `rd_data` |
| irq | output | 1 | Interrupt level |
| overrun | output | 1 | Sticky flag for a word lost to a full queue |
| ovr_clr | input | 1 | Clears `overrun` |

## Verification
A slip in the bit counter or the oversample count would show one character later as a rotated or shifted word on `rd_data`. It can also show as a missing word when the stop sample falls on a data bit. A filter that tests the wrong bit or the wrong format would show as `rd_valid` rising for a data byte under `addr_en` (or failing to rise for an address) within a few clocks of the stop bit's middle. A queue pointer or count error would show at the next pops as words out of order, or as `irq` or `overrun` moving at the wrong fill level.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int WORD_W = 9;
  localparam logic [1:0] FMT_NINE = 2'd3;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/uart9_bit_engine.sv
module uart9_bit_engine
  import uart9_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              nine_sel,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              word_nine
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] C_A   = CW'(MID - 1);
  localparam logic [CW-1:0] C_B   = CW'(MID);
  localparam logic [CW-1:0] C_V   = CW'(MID + 1);
  localparam logic [CW-1:0] C_END = CW'(OSR - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [3:0]        bit_idx;
  logic [WORD_W-1:0] sh;
  logic              s_a, s_b, nine_q;
  logic              vote;
  logic [3:0]        last_idx;

  // two stored samples plus the live one
  assign vote      = (s_a & s_b) | (s_a & rxd) | (s_b & rxd);
  assign last_idx  = nine_q ? 4'd8 : 4'd7;
  assign word_nine = nine_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      sh       <= '0;
      s_a      <= 1'b1;
      s_b      <= 1'b1;
      nine_q   <= 1'b0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rxd) begin
              state  <= RX_START;
              cnt    <= '0;
              nine_q <= nine_sel;
            end
          end
          RX_HOLD: begin
            if (rxd) state <= RX_IDLE;
          end
          default: begin
            cnt <= cnt + 1'b1;
            if (cnt == C_A) s_a <= rxd;
            if (cnt == C_B) s_b <= rxd;
            if (cnt == C_V) begin
              if (state == RX_START && vote) state <= RX_IDLE;
              if (state == RX_DATA) sh <= {vote, sh[WORD_W-1:1]};
              if (state == RX_STOP) begin
                if (vote) begin
                  word_vld <= 1'b1;
                  word     <= nine_q ? sh : {1'b0, sh[WORD_W-1:1]};
                  state    <= RX_IDLE;
                end else begin
                  state <= RX_HOLD;
                end
              end
            end
            if (cnt == C_END) begin
              if (state == RX_START) begin
                state   <= RX_DATA;
                bit_idx <= '0;
              end else if (state == RX_DATA) begin
                if (bit_idx == last_idx) state <= RX_STOP;
                else bit_idx <= bit_idx + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  // R2
  word_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  // R12
  hold_no_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_HOLD) |=> !word_vld);
endmodule

// File: rtl/uart9_addr_gate.sv
module uart9_addr_gate (
  input  logic word_vld,
  input  logic mark_bit,
  input  logic nine_fmt,
  input  logic addr_en,
  input  logic q_full,
  output logic push,
  output logic ovr_set
);
  logic accept;

  // data-marked nine-bit words are dropped while filtering
  assign accept  = word_vld && !(addr_en && nine_fmt && !mark_bit);
  assign push    = accept && !q_full;
  assign ovr_set = accept && q_full;
endmodule

// File: rtl/uart9_fifo.sv
module uart9_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (count != FULL);
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);

  // R9
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != FULL));
endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx
  import uart9_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int DEPTH    = 4,
  parameter int IRQ_PART = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              addr_en,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        irq_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              irq,
  output logic              overrun,
  input  logic              ovr_clr
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LVL_PART = CW'(IRQ_PART);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);

  logic [1:0]        sync_q;
  logic              rxd_s;
  logic              word_vld, word_nine;
  logic [WORD_W-1:0] word;
  logic              push, ovr_set;
  logic [CW-1:0]     count;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end
  assign rxd_s = sync_q[1];

  uart9_bit_engine #(.OSR(OSR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .rxd       (rxd_s),
    .nine_sel  (fmt_sel == FMT_NINE),
    .word_vld  (word_vld),
    .word      (word),
    .word_nine (word_nine)
  );

  uart9_addr_gate u_gate (
    .word_vld (word_vld),
    .mark_bit (word[WORD_W-1]),
    .nine_fmt (word_nine),
    .addr_en  (addr_en),
    .q_full   (count == LVL_FULL),
    .push     (push),
    .ovr_set  (ovr_set)
  );

  uart9_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (word),
    .pop   (rd_valid && rd_ready),
    .dout  (rd_data),
    .count (count)
  );

  assign rd_valid = (count != '0);

  always_comb begin
    case (irq_sel)
      2'd2:    irq = (count >= LVL_PART);
      2'd3:    irq = (count == LVL_FULL);
      default: irq = (count != '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (ovr_set) overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  // R4
  addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && addr_en && word_nine && !word[WORD_W-1]) |-> !push);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);

  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> overrun);

  // R8
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rd_valid);
endmodule

// File: tb/uart9_addr_rx_test.sv
module uart9_addr_rx_test;
  localparam int BT = 32;  // tick every second clock, 16 ticks per bit

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       addr_en = 1'b0;
  logic [1:0] fmt_sel = 2'd3;
  logic [1:0] irq_sel = 2'd0;
  logic [8:0] rd_data;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic       irq;
  logic       overrun;
  logic       ovr_clr = 1'b0;

  int  checks = 0;
  int  errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  uart9_addr_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .addr_en(addr_en), .fmt_sel(fmt_sel), .irq_sel(irq_sel),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .irq(irq), .overrun(overrun), .ovr_clr(ovr_clr)
  );

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  // {addr_en, fmt_sel, word, expect_queued}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 2'd3, 9'h1A5, 1'b1},  // R2 R6 marked word, filter off
    {1'b0, 2'd3, 9'h05A, 1'b1},  // R6 unmarked word, filter off
    {1'b0, 2'd0, 9'h0C3, 1'b1},  // R3 eight-bit frame
    {1'b0, 2'd2, 9'h07E, 1'b1},  // R3 eight-bit frame, other select
    {1'b1, 2'd3, 9'h033, 1'b0},  // R4 data byte dropped
    {1'b1, 2'd3, 9'h1C4, 1'b1},  // R5 address byte kept
    {1'b1, 2'd1, 9'h0F0, 1'b1},  // R3 filter applies to nine-bit only
    {1'b1, 2'd3, 9'h000, 1'b0}   // R4 zero data byte dropped
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input logic [8:0] w, input int nb, input logic stop_lvl,
                            input int glitch_bit);
    rxd = 1'b0;
    wait_clk(BT);
    for (int i = 0; i < nb; i++) begin
      rxd = w[i];
      if (i == glitch_bit) begin
        wait_clk(15);
        rxd = ~w[i];
        wait_clk(2);
        rxd = w[i];
        wait_clk(BT - 17);
      end else begin
        wait_clk(BT);
      end
    end
    rxd = stop_lvl;
    wait_clk(BT);
    rxd = 1'b1;
  endtask

  task automatic pop_word();
    rd_ready = 1'b1;
    wait_clk(1);
    rd_ready = 1'b0;
  endtask

  initial begin
    logic       ae, ex;
    logic [1:0] fm;
    logic [8:0] wd;
    wait_clk(5);
    chk("R1 rd_valid after reset", rd_valid, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 overrun after reset", overrun, 0);
    rst_n = 1'b1;
    wait_clk(BT);

    for (int v = 0; v < 8; v++) begin
      {ae, fm, wd, ex} = VEC[v];
      addr_en = ae;
      fmt_sel = fm;
      send_frame(wd, (fm == 2'd3) ? 9 : 8, 1'b1, -1);
      wait_clk(4);
      chk($sformatf("table vector %0d rd_valid", v), rd_valid, ex);
      chk($sformatf("table vector %0d irq", v), irq, ex);
      if (ex) begin
        chk($sformatf("table vector %0d rd_data", v), rd_data,
            (fm == 2'd3) ? wd : {1'b0, wd[7:0]});
        pop_word();
      end
      wait_clk(BT);
    end

    // R7 R8 R9: fill, thresholds, overflow, order
    addr_en = 1'b0;
    fmt_sel = 2'd3;
    irq_sel = 2'd2;
    send_frame(9'h101, 9, 1'b1, -1); wait_clk(4);
    chk("R8 level 3 with one word", irq, 0);
    send_frame(9'h0A2, 9, 1'b1, -1); wait_clk(4);
    chk("R8 level 3 with two words", irq, 0);
    send_frame(9'h1F3, 9, 1'b1, -1); wait_clk(4);
    chk("R8 level 3 with three words", irq, 1);
    irq_sel = 2'd3;
    wait_clk(1);
    chk("R8 full level with three words", irq, 0);
    send_frame(9'h044, 9, 1'b1, -1); wait_clk(4);
    chk("R8 full level with four words", irq, 1);
    chk("R9 no overrun at exactly full", overrun, 0);
    send_frame(9'h155, 9, 1'b1, -1); wait_clk(4);
    chk("R9 overrun on fifth word", overrun, 1);
    irq_sel = 2'd1;
    wait_clk(1);
    chk("R8 any-word level", irq, 1);
    chk("R7 first out", rd_data, 9'h101); pop_word();
    chk("R7 second out", rd_data, 9'h0A2); pop_word();
    chk("R7 third out", rd_data, 9'h1F3); pop_word();
    chk("R7 fourth out", rd_data, 9'h044); pop_word();
    chk("R9 fifth word was dropped", rd_valid, 0);
    chk("R9 overrun sticky", overrun, 1);
    ovr_clr = 1'b1; wait_clk(1); ovr_clr = 1'b0;
    chk("R9 overrun cleared", overrun, 0);
    rd_ready = 1'b1; wait_clk(2); rd_ready = 1'b0;
    chk("R7 ready on empty queue", rd_valid, 0);

    // R10: short low pulse
    wait_clk(BT);
    rxd = 1'b0; wait_clk(6); rxd = 1'b1;
    wait_clk(BT * 12);
    chk("R10 false start gives no word", rd_valid, 0);
    send_frame(9'h1B6, 9, 1'b1, -1); wait_clk(4);
    chk("R10 receive after false start", rd_data, 9'h1B6);
    pop_word();

    // R11: glitches near mid-bit
    wait_clk(BT);
    send_frame(9'h0D9, 9, 1'b1, 3); wait_clk(4);
    chk("R11 glitch on a one bit", rd_data, 9'h0D9);
    pop_word();
    wait_clk(BT);
    send_frame(9'h0D9, 9, 1'b1, 2); wait_clk(4);
    chk("R11 glitch on a zero bit", rd_data, 9'h0D9);
    pop_word();

    // R12: low stop bit, line kept low, then released
    wait_clk(BT);
    send_frame(9'h0FF, 9, 1'b0, -1);
    rxd = 1'b0;
    wait_clk(BT * 3);
    rxd = 1'b1;
    wait_clk(BT * 12);
    chk("R12 bad stop drops word", rd_valid, 0);
    send_frame(9'h12C, 9, 1'b1, -1); wait_clk(4);
    chk("R12 receive after bad stop", rd_data, 9'h12C);
    chk("R12 one word queued", rd_valid, 1);
    pop_word();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule